// File: doc/BRIEF.md
# Set/Clear/Toggle GPIO Port Controller

This block is one port of general-purpose I/O pins. It sits on a simple memory-mapped bus. Each pin has a set of control bits: GPIO ownership, output enable, output value, open-drain mode, pull-up enable, input filter enable, and a two-bit peripheral function select. Software never writes a control register directly. Every register is modified through atomic aliases. One address ORs the written word into the register and another clears the bits written as one. For the output value there is also a third address that inverts the bits written as one. As a result, two drivers touching different pins never need a read-modify-write.

The block drives per-pin output level, output enable and pull-up signals toward the pads. When a pin is owned by GPIO, its output enable and level come from the GPIO registers. When a pin is handed to a peripheral, the function select code routes one of three peripheral sources (A, B or C) to the pin. The pad level is passed through a two-flop synchronizer. An optional per-pin two-sample filter follows it, and the result is held in a readable pin-level register. In a multi-port system, the upper bits of a global pin number pick the port and the low five bits pick the pin within it. Each port instance is then one copy of this block.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset, the ownership register reads all ones. The output enable, output value, open-drain, pull-up, filter, both function-select and pin-level registers read zero. No pad is driven and no pull-up is on.
- R2: Bus address is register index times four plus slot. A write to slot 1 of a control register ORs the written word into it and leaves the bits written as zero unchanged.
- R3: A write to slot 2 of a control register clears exactly the bits written as one.
- R4: A write to slot 3 of the output value register (index 2) inverts the bits written as one. Slot 3 writes to any other register leave it unchanged.
- R5: Register indices are: 0 ownership (1 = GPIO), 1 output enable, 2 output value, 3 open-drain, 4 pull-up, 5 filter enable, 6 function-select low bit, 7 function-select high bit, 8 pin level. Reading any slot of an index returns that register. Indices 9 and above read zero. Writes to slot 0 change nothing.
- R6: A GPIO-owned pin in push-pull mode has its pad output enable equal to its output enable bit and its pad level equal to its output value bit.
- R7: With open-drain set, the pad level is 0. The pad is enabled only when the selected source enables it and its level is 0. A source level of 1 releases the pad.
- R8: For a peripheral-owned pin, function code {high,low} = 01 selects source B and 10 selects source C. Codes 00 and 11 select source A, both for level and for output enable.
- R9: With the filter off, a pad level change applied before clock edge k is readable in the pin-level register after edge k+2.
- R10: With the filter on, the pin-level register only takes a synchronized value seen on two consecutive cycles. A stable change is readable after edge k+3, and a one-cycle pulse never appears.
- R11: The pull-up output of each pin equals its pull-up bit, whatever the ownership.
- R12: The pin-level register (index 8) is read-only. Set or clear writes to it leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, one write per cycle |
| busAddr | input | ADDR_W | Word address: register index in upper bits, slot in bits 1:0 |
| busWrData | input | NUM_PINS | Write mask |
| busRdData | output | NUM_PINS | Read data for busAddr, combinational |
| padIn | input | NUM_PINS | Pad levels, asynchronous |
| padOut | output | NUM_PINS | Level driven to each pad |
| padOe | output | NUM_PINS | Pad driver enable |
| padPullUp | output | NUM_PINS | Pull-up enable per pad |
| fnAOut | input | NUM_PINS | Peripheral source A level |
| fnAOe | input | NUM_PINS | Peripheral source A drive enable |
| fnBOut | input | NUM_PINS | Peripheral source B level |
| fnBOe | input | NUM_PINS | Peripheral source B drive enable |
| fnCOut | input | NUM_PINS | Peripheral source C level |
| fnCOe | input | NUM_PINS | Peripheral source C drive enable |

## Verification
The bench builds the block with NUM_PINS = 8 and ADDR_W = 6. With an 8-bit write mask, every one of the 256 masks can be applied as a set, a clear and a toggle to every register, with each result compared against an arithmetic model. The narrow port also makes the pad path fully enumerable. All 64 combinations of ownership, enable, value, open-drain and function code are crossed with all 64 combinations of the three peripheral sources. The synchronizer and filter are probed cycle by cycle around their latency edges.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int NUM_RW_REGS = 8;
  localparam int IDX_W       = 4;

  localparam int IDX_OWN   = 0;
  localparam int IDX_OEN   = 1;
  localparam int IDX_OVAL  = 2;
  localparam int IDX_ODRN  = 3;
  localparam int IDX_PULL  = 4;
  localparam int IDX_GFLT  = 5;
  localparam int IDX_FSEL0 = 6;
  localparam int IDX_FSEL1 = 7;
  localparam int IDX_PIN   = 8;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TGL  = 2'd3
  } wrOp_e;

  typedef struct packed {
    logic [NUM_RW_REGS-1:0] regHit;
    wrOp_e                  op;
    logic [IDX_W-1:0]       rdIdx;
  } busStrobe_t;

endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
  import pinbank_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        stb
);

  localparam int IDXF_W = ADDR_W - 2;

  logic [IDXF_W-1:0] fullIdx;
  assign fullIdx = busAddr[ADDR_W-1:2];

  always_comb begin
    stb.regHit = '0;
    for (int r = 0; r < NUM_RW_REGS; r++) begin
      stb.regHit[r] = busWrEn && (fullIdx == IDXF_W'(r));
    end
    // slot 0 is a plain read address: no write operation
    stb.op    = busWrEn ? wrOp_e'(busAddr[1:0]) : OP_NONE;
    stb.rdIdx = (fullIdx <= IDXF_W'(IDX_PIN)) ? IDX_W'(fullIdx) : '1;
  end

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  busStrobe_t                           stb,
  input  logic [NUM_PINS-1:0]                  wrData,
  input  logic [NUM_PINS-1:0]                  padIn,
  output logic [NUM_RW_REGS-1:0][NUM_PINS-1:0] ctrlQ,
  output logic [NUM_PINS-1:0]                  rdData
);

  // control register bank, one generated register per index
  for (genvar r = 0; r < NUM_RW_REGS; r++) begin : g_reg
    localparam logic [NUM_PINS-1:0] RST_VAL = (r == IDX_OWN) ? '1 : '0;
    localparam bit CAN_TGL = (r == IDX_OVAL);
    logic [NUM_PINS-1:0] q;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        q <= RST_VAL;
      end else if (stb.regHit[r]) begin
        case (stb.op)
          OP_SET: q <= q | wrData;
          OP_CLR: q <= q & ~wrData;
          OP_TGL: if (CAN_TGL) q <= q ^ wrData;
          default: ;
        endcase
      end
    end

    assign ctrlQ[r] = q;
  end

  // pad input: two-flop synchronizer, then optional two-sample filter
  logic [NUM_PINS-1:0] syncA, syncB, prevB, pinVal, accept;

  assign accept = ~ctrlQ[IDX_GFLT] | ~(syncB ^ prevB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      prevB  <= '0;
      pinVal <= '0;
    end else begin
      syncA  <= padIn;
      syncB  <= syncA;
      prevB  <= syncB;
      pinVal <= (accept & syncB) | (~accept & pinVal);
    end
  end

  // read multiplexer
  always_comb begin
    rdData = '0;
    if (stb.rdIdx < IDX_W'(NUM_RW_REGS)) begin
      rdData = ctrlQ[stb.rdIdx[2:0]];
    end else if (stb.rdIdx == IDX_W'(IDX_PIN)) begin
      rdData = pinVal;
    end
  end

endmodule

// File: rtl/pinbank_padmux.sv
module pinbank_padmux
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_RW_REGS-1:0][NUM_PINS-1:0] ctrlQ,
  input  logic [NUM_PINS-1:0]                  fnAOut,
  input  logic [NUM_PINS-1:0]                  fnAOe,
  input  logic [NUM_PINS-1:0]                  fnBOut,
  input  logic [NUM_PINS-1:0]                  fnBOe,
  input  logic [NUM_PINS-1:0]                  fnCOut,
  input  logic [NUM_PINS-1:0]                  fnCOe,
  output logic [NUM_PINS-1:0]                  padOut,
  output logic [NUM_PINS-1:0]                  padOe,
  output logic [NUM_PINS-1:0]                  padPullUp
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [1:0] fnCode;
    logic       fnLvl, fnEn, srcLvl, srcEn, openDrain;

    assign fnCode    = {ctrlQ[IDX_FSEL1][i], ctrlQ[IDX_FSEL0][i]};
    assign openDrain = ctrlQ[IDX_ODRN][i];

    always_comb begin
      case (fnCode)
        2'b01:   begin fnLvl = fnBOut[i]; fnEn = fnBOe[i]; end
        2'b10:   begin fnLvl = fnCOut[i]; fnEn = fnCOe[i]; end
        default: begin fnLvl = fnAOut[i]; fnEn = fnAOe[i]; end
      endcase
    end

    assign srcLvl = ctrlQ[IDX_OWN][i] ? ctrlQ[IDX_OVAL][i] : fnLvl;
    assign srcEn  = ctrlQ[IDX_OWN][i] ? ctrlQ[IDX_OEN][i]  : fnEn;

    assign padOe[i]  = openDrain ? (srcEn & ~srcLvl) : srcEn;
    assign padOut[i] = openDrain ? 1'b0 : srcLvl;
  end

  assign padPullUp = ctrlQ[IDX_PULL];

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [NUM_PINS-1:0] busWrData,
  output logic [NUM_PINS-1:0] busRdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padPullUp,
  input  logic [NUM_PINS-1:0] fnAOut,
  input  logic [NUM_PINS-1:0] fnAOe,
  input  logic [NUM_PINS-1:0] fnBOut,
  input  logic [NUM_PINS-1:0] fnBOe,
  input  logic [NUM_PINS-1:0] fnCOut,
  input  logic [NUM_PINS-1:0] fnCOe
);

  busStrobe_t                           stb;
  logic [NUM_RW_REGS-1:0][NUM_PINS-1:0] ctrlQ;

  pinbank_decode #(.ADDR_W(ADDR_W)) uDecode (
    .busWrEn (busWrEn),
    .busAddr (busAddr),
    .stb     (stb)
  );

  pinbank_regs #(.NUM_PINS(NUM_PINS)) uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (busWrData),
    .padIn  (padIn),
    .ctrlQ  (ctrlQ),
    .rdData (busRdData)
  );

  pinbank_padmux #(.NUM_PINS(NUM_PINS)) uPadMux (
    .ctrlQ     (ctrlQ),
    .fnAOut    (fnAOut),
    .fnAOe     (fnAOe),
    .fnBOut    (fnBOut),
    .fnBOe     (fnBOe),
    .fnCOut    (fnCOut),
    .fnCOe     (fnCOe),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullUp (padPullUp)
  );

endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk
  import pinbank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6
) (
  input logic                                 clk,
  input logic                                 rstN,
  input logic                                 busWrEn,
  input logic [ADDR_W-1:0]                    busAddr,
  input logic [NUM_PINS-1:0]                  busWrData,
  input logic [NUM_PINS-1:0]                  padOut,
  input logic [NUM_PINS-1:0]                  padOe,
  input logic [NUM_RW_REGS-1:0][NUM_PINS-1:0] ctrlQ
);

  localparam logic [ADDR_W-1:0] A_OVAL_SET = ADDR_W'(IDX_OVAL * 4 + 1);
  localparam logic [ADDR_W-1:0] A_OVAL_TGL = ADDR_W'(IDX_OVAL * 4 + 3);
  localparam logic [ADDR_W-1:0] A_OEN_CLR  = ADDR_W'(IDX_OEN * 4 + 2);
  localparam logic [ADDR_W-1:0] A_OWN_TGL  = ADDR_W'(IDX_OWN * 4 + 3);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |=> (ctrlQ[IDX_OWN] == '1) && (ctrlQ[IDX_OEN] == '0) && (padOe == '0));

  // R2
  oval_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == A_OVAL_SET
    |=> ctrlQ[IDX_OVAL] == ($past(ctrlQ[IDX_OVAL]) | $past(busWrData)));

  // R3
  oen_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == A_OEN_CLR
    |=> ctrlQ[IDX_OEN] == ($past(ctrlQ[IDX_OEN]) & ~$past(busWrData)));

  // R4
  oval_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == A_OVAL_TGL
    |=> ctrlQ[IDX_OVAL] == ($past(ctrlQ[IDX_OVAL]) ^ $past(busWrData)));

  // R4
  own_no_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == A_OWN_TGL |=> $stable(ctrlQ[IDX_OWN]));

  // R6
  gpio_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[IDX_OWN][0] && !ctrlQ[IDX_ODRN][0]
    |-> padOe[0] == ctrlQ[IDX_OEN][0] && padOut[0] == ctrlQ[IDX_OVAL][0]);

  // R7
  open_drain_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[IDX_ODRN][0] |-> !padOut[0]);

endmodule

bind pinbank_ctrl pinbank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .padOut    (padOut),
  .padOe     (padOe),
  .ctrlQ     (ctrlQ)
);

// File: tb/pinbank_ctrl_test.sv
`timescale 1ns/1ps
module pinbank_ctrl_test;

  localparam int NP = 8;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWrEn = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [NP-1:0] busWrData = '0;
  logic [NP-1:0] busRdData;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut, padOe, padPullUp;
  logic [NP-1:0] fnAOut = '0, fnAOe = '0, fnBOut = '0, fnBOe = '0, fnCOut = '0, fnCOe = '0;

  int nChecks = 0;
  int nFails  = 0;
  logic [NP-1:0] mdl [0:7];

  always #2 clk = ~clk;

  pinbank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padPullUp(padPullUp),
    .fnAOut(fnAOut), .fnAOe(fnAOe), .fnBOut(fnBOut), .fnBOe(fnBOe),
    .fnCOut(fnCOut), .fnCOe(fnCOe)
  );

  task automatic chk(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(int idx, int slot, logic [NP-1:0] d);
    @(negedge clk);
    busAddr   = AW'(idx * 4 + slot);
    busWrData = d;
    busWrEn   = 1'b1;
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  task automatic rdChk(string req, int idx, int slot, logic [NP-1:0] exp);
    busAddr = AW'(idx * 4 + slot);
    #1;
    chk(req, busRdData, exp);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R1: reset state, observed while reset is held
    repeat (3) @(negedge clk);
    for (int r = 0; r < 9; r++) rdChk("R1", r, 0, (r == 0) ? 8'hFF : 8'h00);
    chk("R1 padOe", padOe, 8'h00);
    chk("R1 padPullUp", padPullUp, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    for (int r = 0; r < 8; r++) mdl[r] = (r == 0) ? 8'hFF : 8'h00;

    // R2/R3/R5/R11: every mask, set then clear, on every control register
    for (int r = 0; r < 8; r++) begin
      for (int m = 0; m < 256; m++) begin
        wr(r, 1, 8'(m));
        mdl[r] = mdl[r] | 8'(m);
        rdChk("R2", r, m % 4, mdl[r]);
        wr(r, 2, 8'(m) ^ 8'h5A);
        mdl[r] = mdl[r] & ~(8'(m) ^ 8'h5A);
        rdChk("R3", r, (m + 1) % 4, mdl[r]);
        if (r == 4) chk("R11", padPullUp, mdl[4]);
      end
    end

    // R4: toggle on output value, every mask
    for (int m = 0; m < 256; m++) begin
      wr(2, 3, 8'(m * 37));
      mdl[2] = mdl[2] ^ 8'(m * 37);
      rdChk("R4", 2, 0, mdl[2]);
    end
    // R4: toggle ignored elsewhere; R5: slot 0 writes ignored
    for (int r = 0; r < 8; r++) begin
      if (r != 2) begin
        wr(r, 3, 8'hFF);
        rdChk("R4 no toggle", r, 0, mdl[r]);
      end
      wr(r, 0, ~mdl[r]);
      rdChk("R5 slot0", r, 0, mdl[r]);
    end
    // R5: out-of-range indices read zero
    for (int r = 9; r < 16; r++) rdChk("R5 hole", r, r % 4, 8'h00);

    // R6/R7/R8: exhaustive pad path
    for (int cfg = 0; cfg < 64; cfg++) begin
      logic [NP-1:0] own, oen, oval, odrn, f0, f1;
      own = {NP{cfg[0]}}; oen = {NP{cfg[1]}}; oval = {NP{cfg[2]}};
      odrn = {NP{cfg[3]}}; f0 = {NP{cfg[4]}}; f1 = {NP{cfg[5]}};
      wr(0, 2, 8'hFF); wr(0, 1, own);
      wr(1, 2, 8'hFF); wr(1, 1, oen);
      wr(2, 2, 8'hFF); wr(2, 1, oval);
      wr(3, 2, 8'hFF); wr(3, 1, odrn);
      wr(6, 2, 8'hFF); wr(6, 1, f0);
      wr(7, 2, 8'hFF); wr(7, 1, f1);
      for (int p = 0; p < 64; p++) begin
        logic sl, se, eo, ee;
        fnAOut = {NP{p[0]}}; fnAOe = {NP{p[1]}};
        fnBOut = {NP{p[2]}}; fnBOe = {NP{p[3]}};
        fnCOut = {NP{p[4]}}; fnCOe = {NP{p[5]}};
        #1;
        if (cfg[0]) begin sl = cfg[2]; se = cfg[1]; end
        else if (cfg[5:4] == 2'b01) begin sl = p[2]; se = p[3]; end
        else if (cfg[5:4] == 2'b10) begin sl = p[4]; se = p[5]; end
        else begin sl = p[0]; se = p[1]; end
        if (cfg[3]) begin eo = 1'b0; ee = se & ~sl; end
        else begin eo = sl; ee = se; end
        chk(cfg[3] ? "R7 padOut" : (cfg[0] ? "R6 padOut" : "R8 padOut"), padOut, {NP{eo}});
        chk(cfg[3] ? "R7 padOe" : (cfg[0] ? "R6 padOe" : "R8 padOe"), padOe, {NP{ee}});
        #1;
      end
    end

    // R9: unfiltered latency
    wr(5, 2, 8'hFF);
    padIn = 8'hA5;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rdChk("R9 early", 8, 0, 8'h00);
    @(posedge clk); @(negedge clk);
    rdChk("R9", 8, 0, 8'hA5);

    // R12: pin level is read-only
    wr(8, 1, 8'h5A);
    rdChk("R12", 8, 0, 8'hA5);
    wr(8, 2, 8'hFF);
    rdChk("R12", 8, 1, 8'hA5);

    // R10: filtered pulse and step
    wr(5, 1, 8'hFF);
    padIn = 8'h5A;
    @(negedge clk);
    padIn = 8'hA5;
    repeat (6) @(negedge clk);
    rdChk("R10 pulse", 8, 0, 8'hA5);
    padIn = 8'h0F;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    rdChk("R10 early", 8, 0, 8'hA5);
    @(posedge clk); @(negedge clk);
    rdChk("R10", 8, 0, 8'h0F);

    finishRun();
  end

endmodule